// File: doc/BRIEF.md
# Indirect Pointer-Data Configuration Table Register

This block sits behind a 16-bit host register window and gives indirect write access to five small configuration tables: a device routing map, a set of trunk mask vectors, a set of trunk ID membership maps, a priority override table and a six-byte switch MAC store. The host picks a table by address. It then writes one word that packs a trigger bit, an entry pointer and the entry data. Each table has its own pointer position and data width inside that word.

An accepted write is held in a pending slot and committed to the addressed entry after a fixed latency of LATENCY clock cycles, where LATENCY is a parameter from 1 to 8. During that time bit 15 of the read word reports busy. Software polls bit 15 until it reads zero before it issues the next write. A host that polls up to 16 times therefore always sees a commit finish. A separate debug port reads any entry back combinationally, so the stored contents can be inspected without disturbing the host window. NPORTS must be 11 or less so that the port fields do not overlap the flag bit of the trunk mask.

Top module: `cfgtab_ptr_reg`

## Requirements
- R1: After reset, busy and overrun are 0. Every routing entry reads 0xF (no route). Every trunk mask vector reads all NPORTS port bits set with the hash flag clear. Every trunk map, priority entry and MAC byte reads 0.
- R2: A host write with bit 15 set to table address 0 (routing), 1 (trunk mask), 2 (trunk map), 3 (priority) or 4 (MAC) is accepted when the block is idle. Host read bit 15 is then 1 for exactly LATENCY cycles after the write edge and returns to 0 as the entry becomes visible. Host read bits 14:0 are always 0.
- R3: For routing writes, bits 12:8 select one of 32 targets and bits 3:0 are the egress port. Debug reads return the port in bits 3:0.
- R4: For trunk mask writes, bits 14:12 select one of 8 vectors, bit 11 is the hash flag and bits NPORTS-1:0 are the mask. Debug reads return the same layout.
- R5: For trunk map writes, bits 14:11 select one of 16 IDs and bits NPORTS-1:0 are the member ports. Debug reads return the map in the low bits.
- R6: For priority writes, bits 11:8 select one of 16 entries and only bits 2:0 are stored.
- R7: For MAC writes, bits 11:8 select byte 0 to 5 and bits 7:0 carry the byte. Pointers 6 to 15 still run a busy period but store nothing.
- R8: Data bits between NPORTS and the field above them are dropped for trunk mask and trunk map writes, so those entries never hold bits at or above NPORTS other than the hash flag.
- R9: Any host write while busy is ignored: it changes no entry and does not extend busy. It sets a sticky overrun output that stays 1 until reset.
- R10: A host write with bit 15 clear changes no entry and starts no busy period.
- R11: Host writes to table addresses 5 to 7 are ignored and start no busy period. Debug reads of those addresses, and of indices beyond a table's depth, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_tab | input | 3 | Table address of the write |
| host_wdata | input | 16 | Trigger, pointer and data word |
| host_rdata | output | 16 | Read word: busy in bit 15, zero elsewhere |
| overrun | output | 1 | Sticky flag for a write made while busy |
| dbg_tab | input | 3 | Debug table select |
| dbg_idx | input | 5 | Debug entry index |
| dbg_data | output | 16 | Debug entry contents, zero-extended |

## Verification
The bench sweeps every entry of every table through the debug port: once after reset, and again after filling each table with patterns that carry junk in the ignored bit fields. A decoder that took a pointer from the wrong bit slice would put data in the wrong slot. One that kept stray data bits would show extra bits set. The length of every busy period is counted against LATENCY, which catches a commit that ends early or late. The tests that probe for ignored writes are a write made while busy, a write without the trigger bit, a write to an unmapped address and MAC pointers past byte 5. A design that let any of these through would show a changed entry, a missing overrun or a spurious busy period.

// File: rtl/cfgtab_pkg.sv
package cfgtab_pkg;

  localparam logic [2:0] TAB_ROUTE = 3'd0;
  localparam logic [2:0] TAB_TMASK = 3'd1;
  localparam logic [2:0] TAB_TMAP  = 3'd2;
  localparam logic [2:0] TAB_PRIO  = 3'd3;
  localparam logic [2:0] TAB_MAC   = 3'd4;

  localparam int WORD_W  = 16;
  localparam int TRIG_B  = 15;
  localparam int IDX_W   = 5;

  function automatic logic tab_mapped(input logic [2:0] t);
    return t <= TAB_MAC;
  endfunction

endpackage

// File: rtl/cfgtab_commit_ctrl.sv
module cfgtab_commit_ctrl
  import cfgtab_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        wr_tab,
  input  logic [WORD_W-1:0] wr_word,
  output logic              busy,
  output logic              overrun,
  output logic              commit,
  output logic [2:0]        pend_tab,
  output logic [WORD_W-1:0] pend_word
);

  localparam int CW = $clog2(LATENCY + 1);

  logic          accept;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic [2:0]    tab_q;
  logic [WORD_W-1:0] word_q;

  assign busy   = (cnt_q != '0);
  assign commit = (cnt_q == CW'(1));
  assign accept = wr && wr_word[TRIG_B] && tab_mapped(wr_tab) && !busy;

  always_comb begin
    cnt_d = cnt_q;
    if (accept)    cnt_d = CW'(LATENCY);
    else if (busy) cnt_d = cnt_q - CW'(1);
  end

  always_comb begin
    ovr_d = ovr_q | (wr && busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tab_q  <= '0;
      word_q <= '0;
    end else if (accept) begin
      tab_q  <= wr_tab;
      word_q <= wr_word;
    end
  end

  assign overrun   = ovr_q;
  assign pend_tab  = tab_q;
  assign pend_word = word_q;

  logic [4:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy ? run_q + 5'd1 : 5'd0;
  end

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 5'(LATENCY));
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_word[TRIG_B] && tab_mapped(wr_tab) && !busy) |=> busy);
  assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy) |=> ($stable(pend_word) && overrun));

endmodule

// File: rtl/cfgtab_store.sv
module cfgtab_store
  import cfgtab_pkg::*;
#(
  parameter int               DEPTH   = 8,
  parameter int               WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [WIDTH-1:0] wdat,
  input  logic [IDX_W-1:0] ridx,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (widx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[i] <= RST_VAL;
      else if (ent_en) mem_q[i] <= wdat;
    end

    assert_entry_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx == IDX_W'(i)) |=> (mem_q[i] == $past(wdat)));
    assert_entry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && widx == IDX_W'(i)) |=> $stable(mem_q[i]));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ridx == IDX_W'(i)) rdata = mem_q[i];
    end
  end

endmodule

// File: rtl/cfgtab_ptr_reg.sv
module cfgtab_ptr_reg
  import cfgtab_pkg::*;
#(
  parameter int NPORTS  = 7,
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [2:0]  host_tab,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        overrun,
  input  logic [2:0]  dbg_tab,
  input  logic [4:0]  dbg_idx,
  output logic [15:0] dbg_data
);

  localparam int ROUTE_N = 32;
  localparam int TMASK_N = 8;
  localparam int TMAP_N  = 16;
  localparam int PRIO_N  = 16;
  localparam int MAC_N   = 6;
  localparam int ROUTE_W = 4;
  localparam int TMASK_W = NPORTS + 1;
  localparam int TMAP_W  = NPORTS;
  localparam int PRIO_W  = 3;
  localparam int MAC_W   = 8;
  localparam int HASH_B  = 11;

  logic              busy, commit;
  logic [2:0]        pend_tab;
  logic [WORD_W-1:0] pend_word;

  cfgtab_commit_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk, .rst_n,
    .wr(host_wr), .wr_tab(host_tab), .wr_word(host_wdata),
    .busy, .overrun, .commit, .pend_tab, .pend_word
  );

  // Field extraction from the pending word
  logic [IDX_W-1:0]   route_idx, tmask_idx, tmap_idx, prio_idx, mac_idx;
  logic [ROUTE_W-1:0] route_dat;
  logic [TMASK_W-1:0] tmask_dat;
  logic [TMAP_W-1:0]  tmap_dat;
  logic [PRIO_W-1:0]  prio_dat;
  logic [MAC_W-1:0]   mac_dat;
  logic route_we, tmask_we, tmap_we, prio_we, mac_we;

  always_comb begin
    route_idx = pend_word[12:8];
    tmask_idx = {2'b00, pend_word[14:12]};
    tmap_idx  = {1'b0, pend_word[14:11]};
    prio_idx  = {1'b0, pend_word[11:8]};
    mac_idx   = {1'b0, pend_word[11:8]};
    route_dat = pend_word[3:0];
    tmask_dat = {pend_word[HASH_B], pend_word[NPORTS-1:0]};
    tmap_dat  = pend_word[NPORTS-1:0];
    prio_dat  = pend_word[2:0];
    mac_dat   = pend_word[7:0];
    route_we  = commit && (pend_tab == TAB_ROUTE);
    tmask_we  = commit && (pend_tab == TAB_TMASK);
    tmap_we   = commit && (pend_tab == TAB_TMAP);
    prio_we   = commit && (pend_tab == TAB_PRIO);
    mac_we    = commit && (pend_tab == TAB_MAC);
  end

  logic [ROUTE_W-1:0] rd_route;
  logic [TMASK_W-1:0] rd_tmask;
  logic [TMAP_W-1:0]  rd_tmap;
  logic [PRIO_W-1:0]  rd_prio;
  logic [MAC_W-1:0]   rd_mac;

  cfgtab_store #(.DEPTH(ROUTE_N), .WIDTH(ROUTE_W), .RST_VAL({ROUTE_W{1'b1}})) u_route (
    .clk, .rst_n, .we(route_we), .widx(route_idx), .wdat(route_dat),
    .ridx(dbg_idx), .rdata(rd_route));

  cfgtab_store #(.DEPTH(TMASK_N), .WIDTH(TMASK_W), .RST_VAL({1'b0, {NPORTS{1'b1}}})) u_tmask (
    .clk, .rst_n, .we(tmask_we), .widx(tmask_idx), .wdat(tmask_dat),
    .ridx(dbg_idx), .rdata(rd_tmask));

  cfgtab_store #(.DEPTH(TMAP_N), .WIDTH(TMAP_W), .RST_VAL('0)) u_tmap (
    .clk, .rst_n, .we(tmap_we), .widx(tmap_idx), .wdat(tmap_dat),
    .ridx(dbg_idx), .rdata(rd_tmap));

  cfgtab_store #(.DEPTH(PRIO_N), .WIDTH(PRIO_W), .RST_VAL('0)) u_prio (
    .clk, .rst_n, .we(prio_we), .widx(prio_idx), .wdat(prio_dat),
    .ridx(dbg_idx), .rdata(rd_prio));

  cfgtab_store #(.DEPTH(MAC_N), .WIDTH(MAC_W), .RST_VAL('0)) u_mac (
    .clk, .rst_n, .we(mac_we), .widx(mac_idx), .wdat(mac_dat),
    .ridx(dbg_idx), .rdata(rd_mac));

  always_comb begin
    case (dbg_tab)
      TAB_ROUTE: dbg_data = 16'(rd_route);
      TAB_TMASK: dbg_data = 16'(rd_tmask[NPORTS-1:0]) | (16'(rd_tmask[NPORTS]) << HASH_B);
      TAB_TMAP:  dbg_data = 16'(rd_tmap);
      TAB_PRIO:  dbg_data = 16'(rd_prio);
      TAB_MAC:   dbg_data = 16'(rd_mac);
      default:   dbg_data = 16'h0000;
    endcase
  end

  assign host_rdata = {busy, 15'h0000};

  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_wr && host_wdata[TRIG_B] && host_tab <= TAB_MAC));
  assert_single_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({route_we, tmask_we, tmap_we, prio_we, mac_we}));

endmodule

// File: tb/cfgtab_ptr_reg_bench.sv
`timescale 1ns/100ps
module cfgtab_ptr_reg_bench;

  localparam int NP  = 7;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [2:0]  host_tab;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        overrun;
  logic [2:0]  dbg_tab;
  logic [4:0]  dbg_idx;
  logic [15:0] dbg_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [15:0] model [8][32];

  always #2.5 clk = ~clk;

  cfgtab_ptr_reg #(.NPORTS(NP), .LATENCY(LAT)) u_cfgtab_ptr_reg (
    .clk, .rst_n, .host_wr, .host_tab, .host_wdata, .host_rdata,
    .overrun, .dbg_tab, .dbg_idx, .dbg_data);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic sweep(input string req);
    for (int t = 0; t < 8; t++) begin
      for (int i = 0; i < 32; i++) begin
        dbg_tab = 3'(t);
        dbg_idx = 5'(i);
        #0.5;
        check(req, dbg_data, model[t][i]);
      end
    end
  endtask

  // Drive one write, then count busy cycles at negedges.
  task automatic wr_count(input logic [2:0] a, input logic [15:0] w, output int n);
    @(negedge clk);
    host_wr = 1'b1; host_tab = a; host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
    n = 0;
    while (host_rdata[15] && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wr_busy(input string req, input logic [2:0] a, input logic [15:0] w);
    int n;
    wr_count(a, w, n);
    check(req, 16'(n), 16'(LAT));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [15:0] raw;
    rst_n = 1'b0; host_wr = 1'b0; host_tab = '0; host_wdata = '0;
    dbg_tab = '0; dbg_idx = '0;
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < 32; i++)
        model[t][i] = (t == 0) ? 16'h000F : (t == 1 && i < 8) ? 16'((1 << NP) - 1) : 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", host_rdata, 16'h0000);
    check("R1 overrun", 16'(overrun), 16'h0);
    sweep("R1 reset contents");

    // R3 routing: junk in bits 14:13 and 7:4
    for (int t = 0; t < 32; t++) begin
      raw = 16'h8000 | 16'((t & 3) << 13) | 16'(t << 8) | 16'((t & 15) << 4) | 16'((t * 7 + 3) & 15);
      wr_busy("R2 busy length routing", 3'd0, raw);
      model[0][t] = 16'((t * 7 + 3) & 15);
    end
    sweep("R3 routing contents");

    // R4 R8 trunk mask
    for (int v = 0; v < 8; v++) begin
      raw = 16'((v * 37 + 16'h5A) & 16'h7FF);
      wr_busy("R2 busy length trunk mask", 3'd1,
              16'h8000 | 16'(v << 12) | 16'((v & 1) << 11) | raw);
      model[1][v] = 16'((v & 1) << 11) | (raw & 16'((1 << NP) - 1));
    end
    sweep("R4 R8 trunk mask contents");

    // R5 R8 trunk map
    for (int id = 0; id < 16; id++) begin
      raw = 16'((id * 91 + 16'h155) & 16'h7FF);
      wr_busy("R2 busy length trunk map", 3'd2, 16'h8000 | 16'(id << 11) | raw);
      model[2][id] = raw & 16'((1 << NP) - 1);
    end
    sweep("R5 R8 trunk map contents");

    // R6 priority
    for (int p = 0; p < 16; p++) begin
      raw = 16'((p * 13 + 5) & 16'hFF);
      wr_busy("R2 busy length priority", 3'd3, 16'h8000 | 16'(p << 8) | raw);
      model[3][p] = raw & 16'h7;
    end
    sweep("R6 priority contents");

    // R7 MAC, pointers past byte 5 store nothing but still busy
    for (int b = 0; b < 16; b++) begin
      raw = 16'((16'hA0 + b * 3) & 16'hFF);
      wr_busy("R7 busy length MAC", 3'd4, 16'h8000 | 16'(b << 8) | raw);
      if (b < 6) model[4][b] = raw;
    end
    sweep("R7 MAC contents");

    // R10 trigger bit clear
    wr_count(3'd3, 16'h0207, n);
    check("R10 no busy", 16'(n), 16'h0);
    sweep("R10 contents unchanged");

    // R11 unmapped table addresses
    for (int a = 5; a < 8; a++) begin
      wr_count(3'(a), 16'h8101, n);
      check("R11 no busy", 16'(n), 16'h0);
    end
    sweep("R11 contents unchanged");
    check("R9 overrun clear before test", 16'(overrun), 16'h0);

    // R9 write while busy
    @(negedge clk);
    host_wr = 1'b1; host_tab = 3'd3; host_wdata = 16'h8502;
    @(negedge clk);
    host_tab = 3'd3; host_wdata = 16'h8605;
    @(negedge clk);
    host_wr = 1'b0;
    n = 2;
    while (host_rdata[15] && n < 20) begin
      n++;
      @(negedge clk);
    end
    check("R9 busy not extended", 16'(n), 16'(LAT + 1));
    model[3][5] = 16'h2;
    check("R9 overrun set", 16'(overrun), 16'h1);
    sweep("R9 second write ignored");
    wr_busy("R2 busy length after overrun", 3'd3, 16'h8603);
    model[3][6] = 16'h3;
    check("R9 overrun sticky", 16'(overrun), 16'h1);
    sweep("R9 contents after overrun");

    finish_run();
  end

endmodule